// File: doc/BRIEF.md
# Endpoint Command Processor

This block runs the commands that software posts to a device controller through two 32-bit parameter registers and one control register. Software fills the parameters, then writes the control register with a command type and the active bit. The block executes the command, clears the active bit when it is finished and, if asked, raises a one-cycle completion event request.

For up to 30 physical endpoints, the block keeps three state bits per endpoint: enabled, halted and stopped. Commands that act on several endpoints take their targets from a bitmap in parameter 0. Bit index 2N selects the outbound direction of endpoint N, and bit 2N+1 selects its inbound direction. Bits 0 and 1 belong to the control endpoint and are never used as targets.

Loading an endpoint context is modelled as a request that lasts a fixed number of cycles. Stop and halt walk the bitmap in ascending order and emit one transfer event request per affected endpoint. The completion code depends on whether that endpoint's ring was empty. The block also holds the control endpoint's ring pointer and maximum packet size, a pending device address and the active device address.

Top module: `ep_cmd_proc`

## Requirements
- R1: After reset the control readback, both parameters, all endpoint enable and run bits, the control-endpoint fields, both addresses and all event and pulse outputs are zero.
- R2: The control register layout is active [0], event request [1], type [7:4] and status [19:16]. A write with bit 0 set starts the command in the stored type. The active bit reads 1 until the command completes, then clears. Status always reads 0 (success).
- R3: A write to parameter 0 (address 0), parameter 1 (address 1) or control (address 2) while active is set is ignored.
- R4: When a command completes with event request set, `cev_req_o` is high for exactly the last active cycle, and `cev_type_o` gives the type. With the request clear, no event is raised.
- R5: Configure (type 4) walks bitmap bits 2 to PW-1 in ascending order. For each set bit it holds `ctx_req_o` with `ctx_pei_o` equal to the bit index for CTX_LAT cycles, then sets that enable bit. Bits 0 and 1 are ignored.
- R6: A write to address 3 clears each enable bit where the data has a 1, at any time, and also clears that endpoint's halted and stopped state.
- R7: A run bit is 1 only when the endpoint is enabled and neither halted nor stopped. A doorbell (`db_valid_i`, `db_pei_i`) clears the stopped state but not the halted state.
- R8: Stop (type 8) marks each enabled target as stopped. It emits a transfer event with code 26 if the ring is not empty. If the ring is empty, it emits code 27 only when `stop_len_ev_en_i` is 1, and otherwise emits nothing. Targets that are not enabled are skipped.
- R9: Halt (type 5) acts like stop, with codes 194 and 195 under `halt_len_ev_en_i`. Clear halt (type 6) clears the halted state of the targets.
- R10: Reset sequence number (type 7) and ring pointer reload (type 9) pulse the target bitmap, with bits 0 and 1 dropped, on `seq_clr_o` and `ring_reload_o` respectively, for one cycle during the final active cycle.
- R11: Initialize EP0 (type 0) loads the ring pointer from {param1, param0[31:4]} and the start cycle state from param0[0]. Update EP0 (type 1) loads the max packet size from param0[31:16].
- R12: Set address (type 2) latches param0[7:0] as the pending address. `status_ok_i` copies the pending address to the device address. `conn_lost_i` clears both, and takes priority.
- R13: A reserved type (3, 10 to 15) completes with success and changes no enable, run, control-endpoint or address state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 param0, 1 param1, 2 control, 3 enable clear |
| wr_data_i | input | 32 | Write data |
| param0_o | output | 32 | Parameter 0 readback |
| param1_o | output | 32 | Parameter 1 readback |
| ctrl_o | output | 32 | Control register readback |
| ep_enabled_o | output | PW | Endpoint enabled bits |
| ep_running_o | output | PW | Endpoint running bits |
| ring_empty_i | input | PW | Per-endpoint ring empty status |
| stop_len_ev_en_i | input | 1 | Report stop on an empty ring |
| halt_len_ev_en_i | input | 1 | Report halt on an empty ring |
| db_valid_i | input | 1 | Doorbell strobe |
| db_pei_i | input | PIW | Doorbell target index |
| status_ok_i | input | 1 | Status stage completed successfully |
| conn_lost_i | input | 1 | Connection lost |
| ctx_req_o | output | 1 | Context load in progress |
| ctx_pei_o | output | PIW | Endpoint index being loaded |
| cev_req_o | output | 1 | Command completion event request |
| cev_type_o | output | 4 | Type of the completed command |
| tev_req_o | output | 1 | Transfer event request |
| tev_pei_o | output | PIW | Endpoint of the transfer event |
| tev_code_o | output | 8 | Completion code of the transfer event |
| seq_clr_o | output | PW | Sequence number reset pulse mask |
| ring_reload_o | output | PW | Ring pointer reload pulse mask |
| ep0_dqptr_o | output | 60 | Control endpoint ring pointer |
| ep0_dcs_o | output | 1 | Control endpoint start cycle state |
| ep0_mps_o | output | 16 | Control endpoint max packet size |
| pend_addr_o | output | 8 | Pending device address |
| dev_addr_o | output | 8 | Active device address |

## Verification
The bench builds the block with N_EP = 15, which gives a full 32-bit target bitmap whose top index, 31, is the last one the walk visits. It sets CTX_LAT to 3 instead of the default, so the total number of context-request cycles per configure command (three per target) reveals any off-by-one in the handshake counter. With 15 endpoints, mixed masks can combine unconfigured, empty-ring and busy-ring targets in a single stop or halt. The ascending order of the transfer events and each empty-ring gating input can then be checked against one another.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;
  localparam logic [3:0] CMD_INIT_EP0 = 4'd0;
  localparam logic [3:0] CMD_EP0_MPS  = 4'd1;
  localparam logic [3:0] CMD_SET_ADDR = 4'd2;
  localparam logic [3:0] CMD_CFG_EP   = 4'd4;
  localparam logic [3:0] CMD_HALT     = 4'd5;
  localparam logic [3:0] CMD_UNHALT   = 4'd6;
  localparam logic [3:0] CMD_SEQ_RST  = 4'd7;
  localparam logic [3:0] CMD_STOP     = 4'd8;
  localparam logic [3:0] CMD_RING_RLD = 4'd9;

  localparam logic [7:0] CC_STOP       = 8'd26;
  localparam logic [7:0] CC_STOP_NOLEN = 8'd27;
  localparam logic [7:0] CC_HALT       = 8'd194;
  localparam logic [7:0] CC_HALT_NOLEN = 8'd195;

  localparam logic [1:0] RA_PARAM0 = 2'd0;
  localparam logic [1:0] RA_PARAM1 = 2'd1;
  localparam logic [1:0] RA_CTRL   = 2'd2;
  localparam logic [1:0] RA_EPCLR  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_CTX, S_DONE} seq_state_e;

  function automatic logic is_walk(input logic [3:0] t);
    return (t == CMD_CFG_EP) || (t == CMD_HALT) || (t == CMD_STOP);
  endfunction
endpackage

// File: rtl/ep_cmd_regs.sv
module ep_cmd_regs
  import ep_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        done_i,
  input  logic        apply_i,
  input  logic        status_ok_i,
  input  logic        conn_lost_i,
  output logic [31:0] param0_o,
  output logic [31:0] param1_o,
  output logic        active_o,
  output logic        ioc_o,
  output logic [3:0]  type_o,
  output logic [59:0] ep0_dqptr_o,
  output logic        ep0_dcs_o,
  output logic [15:0] ep0_mps_o,
  output logic [7:0]  pend_addr_o,
  output logic [7:0]  dev_addr_o
);
  logic wr_ok;
  assign wr_ok = wr_en_i && !active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param0_o <= '0;
      param1_o <= '0;
      active_o <= 1'b0;
      ioc_o    <= 1'b0;
      type_o   <= '0;
    end else begin
      if (wr_ok && wr_addr_i == RA_PARAM0) param0_o <= wr_data_i;
      if (wr_ok && wr_addr_i == RA_PARAM1) param1_o <= wr_data_i;
      if (done_i) begin
        active_o <= 1'b0;
      end else if (wr_ok && wr_addr_i == RA_CTRL) begin
        ioc_o  <= wr_data_i[1];
        type_o <= wr_data_i[7:4];
        if (wr_data_i[0]) active_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep0_dqptr_o <= '0;
      ep0_dcs_o   <= 1'b0;
      ep0_mps_o   <= '0;
    end else if (apply_i) begin
      if (type_o == CMD_INIT_EP0) begin
        ep0_dqptr_o <= {param1_o, param0_o[31:4]};
        ep0_dcs_o   <= param0_o[0];
      end
      if (type_o == CMD_EP0_MPS) ep0_mps_o <= param0_o[31:16];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_addr_o <= '0;
      dev_addr_o  <= '0;
    end else if (conn_lost_i) begin
      pend_addr_o <= '0;
      dev_addr_o  <= '0;
    end else begin
      if (apply_i && type_o == CMD_SET_ADDR) pend_addr_o <= param0_o[7:0];
      if (status_ok_i) dev_addr_o <= pend_addr_o;
    end
  end
endmodule

// File: rtl/ep_cmd_seq.sv
module ep_cmd_seq
  import ep_cmd_pkg::*;
#(
  parameter int PW      = 32,
  parameter int CTX_LAT = 4,
  localparam int PIW    = $clog2(PW),
  localparam int CW     = $clog2(CTX_LAT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           active_i,
  input  logic           ioc_i,
  input  logic [3:0]     type_i,
  input  logic [PW-1:0]  mask_i,
  input  logic [PW-1:0]  en_i,
  input  logic [PW-1:0]  empty_i,
  input  logic           stop_len_en_i,
  input  logic           halt_len_en_i,
  output logic           done_o,
  output logic           apply_o,
  output logic           ctx_req_o,
  output logic [PIW-1:0] ctx_pei_o,
  output logic [PW-1:0]  en_set_o,
  output logic [PW-1:0]  stop_set_o,
  output logic [PW-1:0]  halt_set_o,
  output logic [PW-1:0]  halt_clr_o,
  output logic           cev_req_o,
  output logic           tev_req_o,
  output logic [PIW-1:0] tev_pei_o,
  output logic [7:0]     tev_code_o,
  output logic [PW-1:0]  seq_clr_o,
  output logic [PW-1:0]  ring_reload_o
);
  seq_state_e     st_q, st_d;
  logic [PIW-1:0] idx_q, idx_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           tev_d, adv, last, hit, empty_now;
  logic [7:0]     code_d;
  logic [PW-1:0]  seq_d, rld_d;

  assign last      = (idx_q == PIW'(PW - 1));
  assign hit       = mask_i[idx_q] && en_i[idx_q];
  assign empty_now = empty_i[idx_q];

  always_comb begin
    st_d = st_q; idx_d = idx_q; cnt_d = cnt_q;
    apply_o = 1'b0; done_o = 1'b0; ctx_req_o = 1'b0; adv = 1'b0;
    en_set_o = '0; stop_set_o = '0; halt_set_o = '0; halt_clr_o = '0;
    tev_d = 1'b0; code_d = CC_STOP; seq_d = '0; rld_d = '0;
    unique case (st_q)
      S_IDLE: if (active_i) begin
        if (is_walk(type_i)) begin
          st_d  = S_WALK;
          idx_d = PIW'(2);
        end else begin
          apply_o = 1'b1;
          st_d    = S_DONE;
          if (type_i == CMD_SEQ_RST)  seq_d      = mask_i;
          if (type_i == CMD_RING_RLD) rld_d      = mask_i;
          if (type_i == CMD_UNHALT)   halt_clr_o = mask_i;
        end
      end
      S_WALK: begin
        adv = 1'b1;
        if (type_i == CMD_CFG_EP) begin
          if (mask_i[idx_q]) begin
            adv   = 1'b0;
            st_d  = S_CTX;
            cnt_d = CW'(CTX_LAT - 1);
          end
        end else if (hit) begin
          if (type_i == CMD_STOP) begin
            stop_set_o[idx_q] = 1'b1;
            tev_d  = !empty_now || stop_len_en_i;
            code_d = empty_now ? CC_STOP_NOLEN : CC_STOP;
          end else begin
            halt_set_o[idx_q] = 1'b1;
            tev_d  = !empty_now || halt_len_en_i;
            code_d = empty_now ? CC_HALT_NOLEN : CC_HALT;
          end
        end
      end
      S_CTX: begin
        ctx_req_o = 1'b1;
        if (cnt_q == '0) begin
          en_set_o[idx_q] = 1'b1;
          st_d = S_WALK;
          adv  = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      S_DONE: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (last) st_d = S_DONE;
      else      idx_d = idx_q + PIW'(1);
    end
  end

  assign ctx_pei_o = idx_q;
  assign cev_req_o = (st_q == S_DONE) && ioc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= S_IDLE;
      idx_q         <= '0;
      cnt_q         <= '0;
      tev_req_o     <= 1'b0;
      tev_pei_o     <= '0;
      tev_code_o    <= '0;
      seq_clr_o     <= '0;
      ring_reload_o <= '0;
    end else begin
      st_q          <= st_d;
      idx_q         <= idx_d;
      cnt_q         <= cnt_d;
      tev_req_o     <= tev_d;
      tev_pei_o     <= tev_d ? idx_q : '0;
      tev_code_o    <= tev_d ? code_d : '0;
      seq_clr_o     <= seq_d;
      ring_reload_o <= rld_d;
    end
  end
endmodule

// File: rtl/ep_cmd_epstate.sv
module ep_cmd_epstate #(
  parameter int PW   = 32,
  localparam int PIW = $clog2(PW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PW-1:0]  en_set_i,
  input  logic [PW-1:0]  en_clr_i,
  input  logic [PW-1:0]  stop_set_i,
  input  logic [PW-1:0]  halt_set_i,
  input  logic [PW-1:0]  halt_clr_i,
  input  logic           db_valid_i,
  input  logic [PIW-1:0] db_pei_i,
  output logic [PW-1:0]  en_o,
  output logic [PW-1:0]  run_o
);
  assign en_o[1:0]  = '0;
  assign run_o[1:0] = '0;

  for (genvar i = 2; i < PW; i++) begin : g_ep
    logic en_q, halt_q, stop_q, reinit, db_hit;
    assign reinit = en_set_i[i] || en_clr_i[i];
    assign db_hit = db_valid_i && (db_pei_i == PIW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= 1'b0; halt_q <= 1'b0; stop_q <= 1'b0;
      end else begin
        if (en_set_i[i])      en_q <= 1'b1;
        else if (en_clr_i[i]) en_q <= 1'b0;
        if (reinit)             halt_q <= 1'b0;
        else if (halt_set_i[i]) halt_q <= 1'b1;
        else if (halt_clr_i[i]) halt_q <= 1'b0;
        if (reinit)             stop_q <= 1'b0;
        else if (stop_set_i[i]) stop_q <= 1'b1;
        else if (db_hit)        stop_q <= 1'b0;
      end
    end

    assign en_o[i]  = en_q;
    assign run_o[i] = en_q && !halt_q && !stop_q;
  end
endmodule

// File: rtl/ep_cmd_proc.sv
module ep_cmd_proc
  import ep_cmd_pkg::*;
#(
  parameter int N_EP    = 15,
  parameter int CTX_LAT = 4,
  localparam int PW     = 2 * (N_EP + 1),
  localparam int PIW    = $clog2(PW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [31:0]    wr_data_i,
  output logic [31:0]    param0_o,
  output logic [31:0]    param1_o,
  output logic [31:0]    ctrl_o,
  output logic [PW-1:0]  ep_enabled_o,
  output logic [PW-1:0]  ep_running_o,
  input  logic [PW-1:0]  ring_empty_i,
  input  logic           stop_len_ev_en_i,
  input  logic           halt_len_ev_en_i,
  input  logic           db_valid_i,
  input  logic [PIW-1:0] db_pei_i,
  input  logic           status_ok_i,
  input  logic           conn_lost_i,
  output logic           ctx_req_o,
  output logic [PIW-1:0] ctx_pei_o,
  output logic           cev_req_o,
  output logic [3:0]     cev_type_o,
  output logic           tev_req_o,
  output logic [PIW-1:0] tev_pei_o,
  output logic [7:0]     tev_code_o,
  output logic [PW-1:0]  seq_clr_o,
  output logic [PW-1:0]  ring_reload_o,
  output logic [59:0]    ep0_dqptr_o,
  output logic           ep0_dcs_o,
  output logic [15:0]    ep0_mps_o,
  output logic [7:0]     pend_addr_o,
  output logic [7:0]     dev_addr_o
);
  logic          active, ioc, done, apply;
  logic [3:0]    ctype;
  logic [PW-1:0] mask, en_clr, en_set, stop_set, halt_set, halt_clr;

  assign mask   = param0_o[PW-1:0] & ~PW'(3);
  assign en_clr = (wr_en_i && wr_addr_i == RA_EPCLR) ? wr_data_i[PW-1:0] : '0;
  assign ctrl_o = {12'b0, 4'b0, 8'b0, ctype, 2'b0, ioc, active};
  assign cev_type_o = ctype;

  ep_cmd_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .done_i(done), .apply_i(apply), .status_ok_i, .conn_lost_i,
    .param0_o, .param1_o, .active_o(active), .ioc_o(ioc), .type_o(ctype),
    .ep0_dqptr_o, .ep0_dcs_o, .ep0_mps_o, .pend_addr_o, .dev_addr_o
  );

  ep_cmd_seq #(.PW(PW), .CTX_LAT(CTX_LAT)) u_seq (
    .clk_i, .rst_ni, .active_i(active), .ioc_i(ioc), .type_i(ctype),
    .mask_i(mask), .en_i(ep_enabled_o), .empty_i(ring_empty_i),
    .stop_len_en_i(stop_len_ev_en_i), .halt_len_en_i(halt_len_ev_en_i),
    .done_o(done), .apply_o(apply), .ctx_req_o, .ctx_pei_o,
    .en_set_o(en_set), .stop_set_o(stop_set), .halt_set_o(halt_set),
    .halt_clr_o(halt_clr), .cev_req_o, .tev_req_o, .tev_pei_o, .tev_code_o,
    .seq_clr_o, .ring_reload_o
  );

  ep_cmd_epstate #(.PW(PW)) u_eps (
    .clk_i, .rst_ni, .en_set_i(en_set), .en_clr_i(en_clr),
    .stop_set_i(stop_set), .halt_set_i(halt_set), .halt_clr_i(halt_clr),
    .db_valid_i, .db_pei_i, .en_o(ep_enabled_o), .run_o(ep_running_o)
  );
endmodule

// File: rtl/ep_cmd_chk.sv
module ep_cmd_chk #(
  parameter int PW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_addr_i,
  input logic [31:0]   param0_o,
  input logic [31:0]   ctrl_o,
  input logic [PW-1:0] ep_enabled_o,
  input logic [PW-1:0] ep_running_o,
  input logic          cev_req_o,
  input logic          tev_req_o,
  input logic [7:0]    tev_code_o,
  input logic          ctx_req_o,
  input logic          conn_lost_i,
  input logic [7:0]    dev_addr_o
);
  logic rsv;
  assign rsv = (ctrl_o[7:4] == 4'd3) || (ctrl_o[7:4] > 4'd9);

  // R2
  cev_ends_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cev_req_o |=> !ctrl_o[0]);
  // R4
  cev_needs_ioc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cev_req_o |-> (ctrl_o[1] && ctrl_o[0]));
  // R3
  param_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0 && ctrl_o[0]) |=> $stable(param0_o));
  // R5
  ctx_in_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_req_o |-> (ctrl_o[0] && ctrl_o[7:4] == 4'd4));
  // R7
  run_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_running_o & ~ep_enabled_o) == '0);
  // R8
  tev_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tev_req_o |-> (tev_code_o == 8'd26 || tev_code_o == 8'd27 ||
                   tev_code_o == 8'd194 || tev_code_o == 8'd195));
  // R12
  addr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conn_lost_i |=> (dev_addr_o == 8'd0));
  // R13
  rsv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[0] && rsv) |-> (!tev_req_o && !ctx_req_o));
endmodule

bind ep_cmd_proc ep_cmd_chk #(.PW(PW)) u_chk (.*);

// File: tb/ep_cmd_proc_test.sv
module ep_cmd_proc_test;
  localparam int N_EP = 15;
  localparam int LAT  = 3;
  localparam int PW   = 2 * (N_EP + 1);
  localparam int PIW  = $clog2(PW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [31:0]    param0, param1, ctrl;
  logic [PW-1:0]  en, run, empty = '0;
  logic           stop_len = 1'b0, halt_len = 1'b0;
  logic           db_v = 1'b0;
  logic [PIW-1:0] db_p = '0;
  logic           st_ok = 1'b0, lost = 1'b0;
  logic           ctx_req, cev, tev;
  logic [PIW-1:0] ctx_pei, tev_pei;
  logic [3:0]     cev_type;
  logic [7:0]     tev_code, pend, dev;
  logic [PW-1:0]  seq_clr, rld;
  logic [59:0]    dqptr;
  logic           dcs;
  logic [15:0]    mps;

  ep_cmd_proc #(.N_EP(N_EP), .CTX_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .param0_o(param0), .param1_o(param1), .ctrl_o(ctrl),
    .ep_enabled_o(en), .ep_running_o(run), .ring_empty_i(empty),
    .stop_len_ev_en_i(stop_len), .halt_len_ev_en_i(halt_len),
    .db_valid_i(db_v), .db_pei_i(db_p), .status_ok_i(st_ok), .conn_lost_i(lost),
    .ctx_req_o(ctx_req), .ctx_pei_o(ctx_pei), .cev_req_o(cev), .cev_type_o(cev_type),
    .tev_req_o(tev), .tev_pei_o(tev_pei), .tev_code_o(tev_code),
    .seq_clr_o(seq_clr), .ring_reload_o(rld), .ep0_dqptr_o(dqptr),
    .ep0_dcs_o(dcs), .ep0_mps_o(mps), .pend_addr_o(pend), .dev_addr_o(dev)
  );

  int checks = 0, errors = 0;
  int tev_n, cev_n, ctx_cyc;
  logic [7:0] tev_c[8];
  int tev_p[8];
  logic [3:0] cev_t;
  logic [PW-1:0] seq_seen, rld_seen, ctx_seen;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_db(input int p);
    @(negedge clk); db_v = 1'b1; db_p = PIW'(p);
    @(negedge clk); db_v = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    tev_n = 0; cev_n = 0; ctx_cyc = 0; cev_t = '0;
    seq_seen = '0; rld_seen = '0; ctx_seen = '0;
    do begin
      @(negedge clk);
      n++;
      if (tev && tev_n < 8) begin tev_p[tev_n] = int'(tev_pei); tev_c[tev_n] = tev_code; tev_n++; end
      if (cev) begin cev_n++; cev_t = cev_type; end
      if (ctx_req) begin ctx_cyc++; ctx_seen[ctx_pei] = 1'b1; end
      seq_seen |= seq_clr;
      rld_seen |= rld;
    end while (ctrl[0] && n < 2000);
    chk(!ctrl[0], "R2 active cleared", ctrl, 0);
  endtask

  task automatic run_cmd(input logic [31:0] p0, input logic [31:0] p1, input logic [3:0] t, input logic ioc);
    wr(2'd0, p0);
    wr(2'd1, p1);
    wr(2'd2, {24'b0, t, 2'b0, ioc, 1'b1});
    wait_done();
  endtask

  task automatic t_reset();
    chk(ctrl == 0 && param0 == 0 && param1 == 0, "R1 regs", ctrl, 0);
    chk(en == 0 && run == 0, "R1 ep state", {en, run}, 0);
    chk(dqptr == 0 && !dcs && mps == 0 && pend == 0 && dev == 0, "R1 ep0/addr", {mps, pend, dev}, 0);
    chk(!cev && !tev && !ctx_req && seq_clr == 0 && rld == 0, "R1 pulses", {cev, tev, ctx_req}, 0);
  endtask

  task automatic t_ep0();
    wr(2'd0, 32'h1234_5671);
    wr(2'd1, 32'h0000_ABCD);
    @(negedge clk);
    chk(ctrl[0] == 1'b0, "R2 no start without write", ctrl, 0);
    wr(2'd2, 32'h0000_0001);
    chk(ctrl[0] == 1'b1, "R2 active set", ctrl, 1);
    wait_done();
    chk(dqptr == {32'h0000_ABCD, 28'h123_4567} && dcs, "R11 init ep0", dqptr, {32'h0000_ABCD, 28'h123_4567});
    chk(cev_n == 0, "R4 no event without request", cev_n, 0);
    run_cmd(32'h0040_0000, 0, 4'd1, 1'b1);
    chk(mps == 16'h0040, "R11 mps", mps, 16'h40);
    chk(cev_n == 1 && cev_t == 4'd1, "R4 event once with type", {cev_n, cev_t}, {32'd1, 4'd1});
    chk(ctrl[19:16] == 0, "R2 status success", ctrl[19:16], 0);
  endtask

  task automatic t_cfg();
    run_cmd(32'h8000_000F, 0, 4'd4, 1'b0);
    chk(en == 32'h8000_000C, "R5 enables", en, 32'h8000_000C);
    chk(ctx_cyc == 3 * LAT, "R5 ctx cycles", ctx_cyc, 3 * LAT);
    chk(ctx_seen == 32'h8000_000C, "R5 ctx targets", ctx_seen, 32'h8000_000C);
    chk(run == 32'h8000_000C, "R7 running after config", run, 32'h8000_000C);
  endtask

  task automatic t_ignore();
    wr(2'd0, 32'h0000_0010);
    wr(2'd2, 32'h0000_0041);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h5555_5555);
    wr(2'd2, 32'h0000_0073);
    wait_done();
    chk(param0 == 32'h10 && param1 == 0, "R3 params kept", param0, 32'h10);
    chk(ctrl[7:4] == 4'd4 && !ctrl[1], "R3 ctrl kept", ctrl, 32'h40);
    chk(seq_seen == 0 && cev_n == 0, "R3 no second command", seq_seen, 0);
    chk(en == 32'h8000_001C, "R5 added ep", en, 32'h8000_001C);
  endtask

  task automatic t_stop();
    empty = 32'h8000_0008;
    stop_len = 1'b0;
    run_cmd(32'h0000_002C, 0, 4'd8, 1'b0);
    chk(tev_n == 1 && tev_p[0] == 2 && tev_c[0] == 8'd26, "R8 stop busy only", {tev_n, tev_c[0]}, {32'd1, 8'd26});
    chk(run == 32'h8000_0010, "R7 stopped not running", run, 32'h8000_0010);
    chk(en == 32'h8000_001C, "R8 enables kept", en, 32'h8000_001C);
    stop_len = 1'b1;
    run_cmd(32'h0000_0008, 0, 4'd8, 1'b0);
    chk(tev_n == 1 && tev_p[0] == 3 && tev_c[0] == 8'd27, "R8 stop empty gated", {tev_n, tev_c[0]}, {32'd1, 8'd27});
    stop_len = 1'b0;
    pulse_db(2);
    pulse_db(3);
    @(negedge clk);
    chk(run == 32'h8000_001C, "R7 doorbell resumes", run, 32'h8000_001C);
  endtask

  task automatic t_halt();
    empty = 32'h0000_0008;
    halt_len = 1'b1;
    run_cmd(32'h0000_000C, 0, 4'd5, 1'b0);
    chk(tev_n == 2 && tev_p[0] == 2 && tev_c[0] == 8'd194 && tev_p[1] == 3 && tev_c[1] == 8'd195,
        "R9 halt codes ascending", {tev_c[0], tev_c[1]}, {8'd194, 8'd195});
    halt_len = 1'b0;
    empty = 32'h8000_0000;
    run_cmd(32'h8000_0000, 0, 4'd5, 1'b0);
    chk(tev_n == 0, "R9 halt empty ungated", tev_n, 0);
    chk(run == 32'h0000_0010, "R7 halted not running", run, 32'h10);
    pulse_db(31);
    @(negedge clk);
    chk(run == 32'h0000_0010, "R7 doorbell keeps halt", run, 32'h10);
    run_cmd(32'h8000_000C, 0, 4'd6, 1'b0);
    chk(run == 32'h8000_001C, "R9 clear halt", run, 32'h8000_001C);
  endtask

  task automatic t_pulses();
    run_cmd(32'h0000_0030, 0, 4'd7, 1'b0);
    chk(seq_seen == 32'h30 && rld_seen == 0, "R10 seq reset mask", seq_seen, 32'h30);
    run_cmd(32'h0000_000F, 0, 4'd9, 1'b0);
    chk(rld_seen == 32'h0C && seq_seen == 0, "R10 reload mask", rld_seen, 32'h0C);
  endtask

  task automatic t_addr();
    run_cmd(32'h0000_002A, 0, 4'd2, 1'b0);
    chk(pend == 8'h2A && dev == 0, "R12 pending only", {pend, dev}, 16'h2A00);
    @(negedge clk); st_ok = 1'b1;
    @(negedge clk); st_ok = 1'b0;
    chk(dev == 8'h2A, "R12 status promotes", dev, 8'h2A);
    @(negedge clk); lost = 1'b1; st_ok = 1'b1;
    @(negedge clk); lost = 1'b0; st_ok = 1'b0;
    chk(dev == 0 && pend == 0, "R12 connection loss", {pend, dev}, 0);
  endtask

  task automatic t_w1c();
    wr(2'd3, 32'h8000_0010);
    chk(en == 32'h0000_000C && run == 32'h0000_000C, "R6 clear enables", {en, run}, {32'hC, 32'hC});
  endtask

  task automatic t_rsv();
    run_cmd(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3, 1'b1);
    chk(cev_n == 1 && cev_t == 4'd3 && ctrl[19:16] == 0, "R13 completes", {cev_n, cev_t}, {32'd1, 4'd3});
    run_cmd(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd15, 1'b0);
    chk(en == 32'hC && run == 32'hC && tev_n == 0 && ctx_cyc == 0, "R13 ep state unchanged", en, 32'hC);
    chk(mps == 16'h40 && dqptr == {32'h0000_ABCD, 28'h123_4567} && pend == 0 && dev == 0,
        "R13 ep0/addr unchanged", mps, 16'h40);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ep0();
    t_cfg();
    t_ignore();
    t_stop();
    t_halt();
    t_pulses();
    t_addr();
    t_w1c();
    t_rsv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule